// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This block holds the modem control byte and the modem status byte of a classic byte-wide serial port. It drives the four control outputs: request-to-send, data-terminal-ready and two general-purpose outputs. It samples the four incoming modem lines (clear-to-send, data-set-ready, carrier-detect and ring) through synchronisers. For each line it keeps the current level and a sticky flag that records a change since the last status read. When the host has enabled it, it raises a modem-status interrupt request while any change flag is set.

A control bit selects loopback. In loopback the control outputs are routed internally to the status view instead of the pins, and the external request-to-send and data-terminal-ready outputs are held inactive. Pin activity during loopback is tracked but raises no flag. The host writes the control byte with a one-cycle strobe. It reads the status byte combinationally and pulses a read strobe, which clears the change flags on the following edge.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset the control value is 0x08 (only the second general output set), the status byte reads 0xB0, the interrupt request is low, and the request-to-send and data-terminal-ready outputs are low.
- R2: A control write keeps only data bits 4..0: bit 0 data-terminal-ready, bit 1 request-to-send, bit 2 first general output, bit 3 second general output, bit 4 loopback. The readback has bits 7..5 at zero. Outside loopback each output pin follows its bit from the cycle after the write.
- R3: Status bits 7..4 are the carrier-detect, ring, data-set-ready and clear-to-send levels. Bits 3, 1 and 0 are change flags for carrier-detect, data-set-ready and clear-to-send. A flag is set on either direction of change, three clock edges after the pin changes.
- R4: Status bit 2 is set only when the ring level falls from 1 to 0. A rise of the ring level sets no flag.
- R5: A read outside loopback returns the current byte. The change flags are cleared on that edge and the levels are kept.
- R6: In loopback a read returns the second general output on bit 7, the first general output on bit 6, data-terminal-ready on bit 5 and request-to-send on bit 4, with bits 3..0 at zero.
- R7: In loopback the request-to-send and data-terminal-ready pins are low. Pin changes set no change flag, and a read strobe leaves the stored flags unchanged.
- R8: The interrupt request is high exactly when the enable input is high and at least one change flag is set.
- R9: A change flag stays set until a status read outside loopback clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_value | output | 8 | Control byte readback |
| sts_rd | input | 1 | Status read strobe; clears change flags on the edge |
| sts_rdata | output | 8 | Status byte (loopback view when loopback is on) |
| stat_irq_en | input | 1 | Modem-status interrupt enable |
| line_cts | input | 1 | Clear-to-send level, asynchronous |
| line_dsr | input | 1 | Data-set-ready level, asynchronous |
| line_dcd | input | 1 | Carrier-detect level, asynchronous |
| line_ri | input | 1 | Ring level, asynchronous |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| out1_o | output | 1 | First general output |
| out2_o | output | 1 | Second general output |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that the control write and read strobes are single-cycle pulses driven synchronously to the clock. They also assume that each modem line, once changed, holds its new level for at least the synchroniser depth plus one cycle, so that every change reaches the level register as one clean step. The bench changes the lines and strobes only on falling clock edges. It then waits three rising edges before it inspects the result, and it never toggles a line twice inside that window.

// File: rtl/modem_ctl_status.sv
module modem_ctl_status #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  LINE_RST    = 4'b1011,
  parameter logic [4:0]  CTL_RST     = 5'b01000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_value,
  input  logic       sts_rd,
  output logic [7:0] sts_rdata,
  input  logic       stat_irq_en,
  input  logic       line_cts,
  input  logic       line_dsr,
  input  logic       line_dcd,
  input  logic       line_ri,
  output logic       rts_o,
  output logic       dtr_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       irq_o
);

  localparam int RI_IDX = 2;

  logic [4:0] ctl;
  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] line_s, lvl, delta, chg, set;
  logic       loop;

  assign loop   = ctl[4];
  assign line_s = sync_q[SYNC_STAGES-1];
  assign chg    = lvl ^ line_s;
  assign set    = loop ? 4'b0000
                       : {chg[3], chg[RI_IDX] & lvl[RI_IDX], chg[1], chg[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= LINE_RST;
    end else begin
      sync_q[0] <= {line_dcd, line_ri, line_dsr, line_cts};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= CTL_RST;
      lvl   <= LINE_RST;
      delta <= '0;
    end else begin
      lvl <= line_s;
      if (sts_rd && !loop) delta <= set;
      else                 delta <= delta | set;
      if (ctl_we) ctl <= ctl_wdata[4:0];
    end
  end

  assign ctl_value = {3'b000, ctl};
  assign sts_rdata = loop ? {ctl[3], ctl[2], ctl[0], ctl[1], 4'b0000}
                          : {lvl, delta};
  assign dtr_o  = ctl[0] & ~loop;
  assign rts_o  = ctl[1] & ~loop;
  assign out1_o = ctl[2];
  assign out2_o = ctl[3];
  assign irq_o  = stat_irq_en & (|delta);

  p_ctl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_value[4:0] == $past(ctl_wdata[4:0]));

  p_ri_rise_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl[RI_IDX] && !delta[RI_IDX]) |=> !delta[RI_IDX]);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !loop && lvl == line_s) |=> delta == 4'b0000);

  p_loop_no_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loop |=> (delta & ~$past(delta)) == 4'b0000);

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> stat_irq_en);

  p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_rd && !loop) |=> (delta & $past(delta)) == $past(delta));

endmodule

// File: tb/modem_ctl_status_tb.sv
module modem_ctl_status_tb;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, sts_rd = 0, stat_irq_en = 0;
  logic [7:0] ctl_wdata = 0;
  logic line_cts = 1, line_dsr = 1, line_dcd = 1, line_ri = 0;
  logic [7:0] ctl_value, sts_rdata;
  logic rts_o, dtr_o, out1_o, out2_o, irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modem_ctl_status u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_value(ctl_value), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
    .stat_irq_en(stat_irq_en), .line_cts(line_cts), .line_dsr(line_dsr),
    .line_dcd(line_dcd), .line_ri(line_ri), .rts_o(rts_o), .dtr_o(dtr_o),
    .out1_o(out1_o), .out2_o(out2_o), .irq_o(irq_o));

  // {write data, expected control, 4'b0 + pins {out2,out1,rts,dtr}, expected status view}
  localparam logic [31:0] VEC [7] = '{
    32'h13_13_00_30, 32'hFC_1C_0C_C0, 32'h11_11_00_20, 32'h12_12_00_10,
    32'h0F_0F_0F_B0, 32'hE5_05_05_B0, 32'h1F_1F_0C_F0 };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic rd_sts(output logic [7:0] v);
    @(negedge clk); v = sts_rdata; sts_rd = 1;
    @(negedge clk); sts_rd = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ctl", ctl_value, 8'h08);
    check("R1 status", sts_rdata, 8'hB0);
    check("R1 pins", {4'b0, irq_o, out2_o, rts_o, dtr_o}, 8'h04);

    for (int i = 0; i < 7; i++) begin
      wr_ctl(VEC[i][31:24]);
      check("R2 ctl readback", ctl_value, VEC[i][23:16]);
      check("R2/R7 pins", {4'b0, out2_o, out1_o, rts_o, dtr_o}, VEC[i][15:8]);
      check("R6 status view", sts_rdata, VEC[i][7:0]);
    end
    wr_ctl(8'h08);

    @(negedge clk); line_cts = 0; settle();
    check("R3 cts fall", sts_rdata, 8'hA1);
    check("R8 irq disabled", {7'b0, irq_o}, 8'h00);
    stat_irq_en = 1; @(negedge clk);
    check("R8 irq enabled", {7'b0, irq_o}, 8'h01);
    rd_sts(v);
    check("R5 read value", v, 8'hA1);
    check("R5 after read", sts_rdata, 8'hA0);
    check("R8 irq cleared", {7'b0, irq_o}, 8'h00);

    line_cts = 1; settle();
    check("R3 cts rise", sts_rdata, 8'hB1);
    rd_sts(v);
    check("R5 cleared", sts_rdata, 8'hB0);

    line_dcd = 0; line_dsr = 0; settle();
    check("R3 dcd+dsr fall", sts_rdata, 8'h1A);
    repeat (5) @(negedge clk);
    check("R9 sticky", sts_rdata, 8'h1A);
    rd_sts(v);
    check("R5 read value", v, 8'h1A);
    check("R5 after read", sts_rdata, 8'h10);
    line_dcd = 1; line_dsr = 1; settle();
    check("R3 dcd+dsr rise", sts_rdata, 8'hBA);
    rd_sts(v);

    line_ri = 1; settle();
    check("R4 ring rise no flag", sts_rdata, 8'hF0);
    line_ri = 0; settle();
    check("R4 ring fall flag", sts_rdata, 8'hB4);
    rd_sts(v);
    check("R4 cleared", sts_rdata, 8'hB0);

    wr_ctl(8'h1B);
    check("R7 rts/dtr held low", {6'b0, rts_o, dtr_o}, 8'h00);
    line_cts = 0; settle();
    check("R6 loop view", sts_rdata, 8'hB0);
    wr_ctl(8'h08);
    check("R7 no flag from loop pins", sts_rdata, 8'hA0);
    line_cts = 1; settle();
    check("R3 flag before loop", sts_rdata, 8'hB1);
    wr_ctl(8'h18);
    rd_sts(v);
    check("R6 loop read", v, 8'h80);
    wr_ctl(8'h08);
    check("R7 loop read keeps flag", sts_rdata, 8'hB1);
    check("R8 irq with flag", {7'b0, irq_o}, 8'h01);
    rd_sts(v);
    check("R5 final clear", sts_rdata, 8'hB0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule